// File: doc/BRIEF.md
# Host Register Interface with GPIO Ports and Scratch Bytes

This block sits between a simple 8-bit host bus and the rest of an I/O chip. The bus has an active-low select, read enable and write enable, a 6-bit address and an 8-bit data path. The block samples these on the system clock. A read drives the data path at once with the value of the addressed register. A write stores the value on a rising edge. When the read and write enables are both low, the read wins.

Inside the block are two 8-bit GPIO ports and sixteen scratch bytes. Each GPIO port has a direction register, an output-level register, a synchronised read-only pin view, and pull-up and pull-down enable registers. Addresses 0x06 to 0x2A belong to peripherals outside the block. For these addresses the block forwards a write strobe, the address and the data. On reads it returns the peripheral's data. It also sends one registered read strobe for each read, so a peripheral can apply read side effects such as popping a receive buffer.

The outer bidirectional data pad is split into an input, an output and an output-enable here.

Top module: `hbr_host_regs`

## Requirements
- R1: After synchronous reset, every direction, output-level, pull-up, pull-down, synchroniser and strobe register is zero. The scratch bytes are not reset.
- R2: `bus_doe` is 1 and `bus_dout` carries the addressed value in the same cycle whenever `bus_cs_n`=0 and `bus_oe_n`=0. Otherwise `bus_doe` is 0 and `bus_dout` is 0.
- R3: A register is written on each rising edge where `bus_cs_n`=0, `bus_we_n`=0 and `bus_oe_n`=1. The local map is:
  - direction A/B at 0x00/0x01;
  - output level A/B at 0x02/0x03;
  - pin view A/B at 0x04/0x05;
  - pull-up A/B at 0x2B/0x2C;
  - pull-down A/B at 0x2D/0x2E.
- R4: With select, read enable and write enable all low, no register changes, `ext_wr_stb` stays 0, and the cycle reads.
- R5: These have no effect on any register: writes to the pin views (0x04/0x05), and any cycle with `bus_cs_n`=1.
- R6: The direction bit selects the pin mode, 1 for output and 0 for input, and drives `gpio_oe`. The output-level register drives `gpio_out`. Port A is bits 7:0 and port B is bits 15:8.
- R7: The pin view returns `gpio_in` through a two-flop synchroniser. A pad change that is stable before edge k reads back after edge k+1.
- R8: `gpio_pu_en` and `gpio_pd_en` equal the pull-up and pull-down register bits masked by input direction. They are 0 for every output pin.
- R9: Addresses 0x30 to 0x3F read back the last byte written to each.
- R10: Address 0x2F reads as 0, and writes to it have no effect.
- R11: For addresses 0x06 to 0x2A:
  - reads return `ext_rdata`;
  - `ext_wr_stb` is 1 in the cycle of a qualifying write, with `ext_addr` and `ext_wdata` passing through the bus address and data;
  - no local register changes.
- R12: On the first rising edge of a read cycle to 0x06 to 0x2A, `ext_rd_stb` rises for exactly one clock, with `ext_rd_addr` holding the read address. It does not repeat while the read is held, and it never fires for local addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Active-low select |
| bus_oe_n | input | 1 | Active-low read enable |
| bus_we_n | input | 1 | Active-low write enable |
| bus_addr | input | 6 | Register address |
| bus_din | input | 8 | Write data from host |
| bus_dout | output | 8 | Read data to host |
| bus_doe | output | 1 | Data pad drive enable |
| gpio_in | input | 16 | Pad levels, port B in 15:8 |
| gpio_out | output | 16 | Output levels |
| gpio_oe | output | 16 | Pad output enables |
| gpio_pu_en | output | 16 | Pull-up controls |
| gpio_pd_en | output | 16 | Pull-down controls |
| ext_addr | output | 6 | Address to peripherals |
| ext_wdata | output | 8 | Write data to peripherals |
| ext_wr_stb | output | 1 | Peripheral write strobe |
| ext_rdata | input | 8 | Peripheral read data |
| ext_rd_stb | output | 1 | Registered read side-effect strobe |
| ext_rd_addr | output | 6 | Address captured with the read strobe |

## Verification
The assertions check these on every cycle:
- the read strobe is single-cycle and always caused by a read in the previous cycle;
- an overlapping read and write never produces a peripheral write strobe;
- the write strobe never leaves the peripheral window;
- pull enables never appear on output pins;
- the GPIO direction never changes without a qualifying write;
- reset clears the pads.

Only the bench's scenarios can show the rest. That covers the register map contents, the two-edge pin latency, the scratch storage, the read-as-zero hole, and that a held read produces exactly one strobe while a fresh read produces another.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int DW    = 8;
    localparam int AW    = 6;
    localparam int NPORT = 2;
    localparam int NSCR  = 16;
    localparam int IW    = $clog2(NSCR);

    localparam int BASE_DIR = 'h00;
    localparam int BASE_OUT = 'h02;
    localparam int BASE_PIN = 'h04;
    localparam int BASE_PU  = 'h2B;
    localparam int BASE_PD  = 'h2D;
    localparam int EXT_LO   = 'h06;
    localparam int EXT_HI   = 'h2A;
    localparam int BASE_SCR = 'h30;

    typedef enum logic [2:0] {
        RG_NONE, RG_DIR, RG_OUT, RG_PIN, RG_PU, RG_PD, RG_EXT, RG_SCR
    } region_e;

    typedef struct packed {
        region_e          rg;
        logic [IW-1:0]    idx;
    } dec_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } access_t;

    function automatic logic in_range(input int a, input int base, input int n);
        return (a >= base) && (a < base + n);
    endfunction

    function automatic dec_t decode_addr(input logic [AW-1:0] addr);
        dec_t d;
        int   a;
        a     = int'(addr);
        d.rg  = RG_NONE;
        d.idx = '0;
        if (in_range(a, BASE_DIR, NPORT)) begin
            d.rg = RG_DIR; d.idx = IW'(a - BASE_DIR);
        end else if (in_range(a, BASE_OUT, NPORT)) begin
            d.rg = RG_OUT; d.idx = IW'(a - BASE_OUT);
        end else if (in_range(a, BASE_PIN, NPORT)) begin
            d.rg = RG_PIN; d.idx = IW'(a - BASE_PIN);
        end else if (in_range(a, BASE_PU, NPORT)) begin
            d.rg = RG_PU; d.idx = IW'(a - BASE_PU);
        end else if (in_range(a, BASE_PD, NPORT)) begin
            d.rg = RG_PD; d.idx = IW'(a - BASE_PD);
        end else if (a >= EXT_LO && a <= EXT_HI) begin
            d.rg = RG_EXT;
        end else if (in_range(a, BASE_SCR, NSCR)) begin
            d.rg = RG_SCR; d.idx = IW'(a - BASE_SCR);
        end
        return d;
    endfunction

endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
    import hbr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output access_t       acc,
    output dec_t          dec,
    output logic          rd_stb,
    output logic [AW-1:0] rd_stb_addr
);

    logic rd_seen;

    always_comb begin
        dec    = decode_addr(addr);
        acc.rd = !cs_n && !oe_n;
        acc.wr = !cs_n && !we_n && oe_n;
    end

    // One strobe per read cycle, issued on the first edge that samples it.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_seen     <= 1'b0;
            rd_stb      <= 1'b0;
            rd_stb_addr <= '0;
        end else begin
            rd_seen <= acc.rd;
            rd_stb  <= acc.rd && !rd_seen && (dec.rg == RG_EXT);
            if (acc.rd && !rd_seen)
                rd_stb_addr <= addr;
        end
    end

endmodule

// File: rtl/hbr_gpio_port.sv
module hbr_gpio_port
    import hbr_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  access_t       acc,
    input  dec_t          dec,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pad_in,
    output logic [DW-1:0] pad_out,
    output logic [DW-1:0] pad_oe,
    output logic [DW-1:0] pu_en,
    output logic [DW-1:0] pd_en,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] dir_q, out_q, pu_q, pd_q, sync1_q, sync2_q;
    logic          sel;

    assign sel = (dec.idx == IW'(IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            out_q   <= '0;
            pu_q    <= '0;
            pd_q    <= '0;
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pad_in;
            sync2_q <= sync1_q;
            if (acc.wr && sel) begin
                case (dec.rg)
                    RG_DIR:  dir_q <= wdata;
                    RG_OUT:  out_q <= wdata;
                    RG_PU:   pu_q  <= wdata;
                    RG_PD:   pd_q  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (dec.rg)
                RG_DIR:  rdata = dir_q;
                RG_OUT:  rdata = out_q;
                RG_PIN:  rdata = sync2_q;
                RG_PU:   rdata = pu_q;
                RG_PD:   rdata = pd_q;
                default: rdata = '0;
            endcase
        end
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
    assign pu_en   = pu_q & ~dir_q;
    assign pd_en   = pd_q & ~dir_q;

endmodule

// File: rtl/hbr_scratch.sv
module hbr_scratch
    import hbr_pkg::*;
(
    input  logic          clk,
    input  access_t       acc,
    input  dec_t          dec,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [NSCR];

    always_ff @(posedge clk) begin
        if (acc.wr && dec.rg == RG_SCR)
            mem[dec.idx] <= wdata;
    end

    assign rdata = (dec.rg == RG_SCR) ? mem[dec.idx] : '0;

endmodule

// File: rtl/hbr_host_regs.sv
module hbr_host_regs
    import hbr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_cs_n,
    input  logic                bus_oe_n,
    input  logic                bus_we_n,
    input  logic [5:0]          bus_addr,
    input  logic [7:0]          bus_din,
    output logic [7:0]          bus_dout,
    output logic                bus_doe,
    input  logic [15:0]         gpio_in,
    output logic [15:0]         gpio_out,
    output logic [15:0]         gpio_oe,
    output logic [15:0]         gpio_pu_en,
    output logic [15:0]         gpio_pd_en,
    output logic [5:0]          ext_addr,
    output logic [7:0]          ext_wdata,
    output logic                ext_wr_stb,
    input  logic [7:0]          ext_rdata,
    output logic                ext_rd_stb,
    output logic [5:0]          ext_rd_addr
);

    access_t       acc;
    dec_t          dec;
    logic [DW-1:0] port_rd [NPORT];
    logic [DW-1:0] scr_rd;
    logic [DW-1:0] rd_val;

    hbr_decode u_dec (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (bus_cs_n),
        .oe_n        (bus_oe_n),
        .we_n        (bus_we_n),
        .addr        (bus_addr),
        .acc         (acc),
        .dec         (dec),
        .rd_stb      (ext_rd_stb),
        .rd_stb_addr (ext_rd_addr)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        hbr_gpio_port #(.IDX(p)) u_port (
            .clk     (clk),
            .rst     (rst),
            .acc     (acc),
            .dec     (dec),
            .wdata   (bus_din),
            .pad_in  (gpio_in[p*DW +: DW]),
            .pad_out (gpio_out[p*DW +: DW]),
            .pad_oe  (gpio_oe[p*DW +: DW]),
            .pu_en   (gpio_pu_en[p*DW +: DW]),
            .pd_en   (gpio_pd_en[p*DW +: DW]),
            .rdata   (port_rd[p])
        );
    end

    hbr_scratch u_scr (
        .clk   (clk),
        .acc   (acc),
        .dec   (dec),
        .wdata (bus_din),
        .rdata (scr_rd)
    );

    always_comb begin
        rd_val = scr_rd;
        for (int p = 0; p < NPORT; p++)
            rd_val = rd_val | port_rd[p];
        if (dec.rg == RG_EXT)
            rd_val = ext_rdata;
    end

    assign bus_doe    = acc.rd;
    assign bus_dout   = acc.rd ? rd_val : '0;
    assign ext_addr   = bus_addr;
    assign ext_wdata  = bus_din;
    assign ext_wr_stb = acc.wr && (dec.rg == RG_EXT);

endmodule

// File: rtl/hbr_host_regs_chk.sv
module hbr_host_regs_chk
    import hbr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_cs_n,
    input logic        bus_oe_n,
    input logic        bus_we_n,
    input logic [5:0]  ext_addr,
    input logic        ext_wr_stb,
    input logic        ext_rd_stb,
    input logic [15:0] gpio_oe,
    input logic [15:0] gpio_out,
    input logic [15:0] gpio_pu_en,
    input logic [15:0] gpio_pd_en
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gpio_oe == '0 && gpio_out == '0 && !ext_rd_stb));

    p_dir_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(!bus_cs_n && !bus_we_n && bus_oe_n) |=> $stable(gpio_oe));

    p_read_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && !bus_oe_n) |-> !ext_wr_stb);

    p_no_pull_on_out_r8: assert property (@(posedge clk) disable iff (rst)
        ((gpio_pu_en | gpio_pd_en) & gpio_oe) == '0);

    p_wr_window_r11: assert property (@(posedge clk) disable iff (rst)
        ext_wr_stb |-> (int'(ext_addr) >= EXT_LO && int'(ext_addr) <= EXT_HI));

    p_rd_stb_single_r12: assert property (@(posedge clk) disable iff (rst)
        ext_rd_stb |=> !ext_rd_stb);

    p_rd_stb_cause_r12: assert property (@(posedge clk) disable iff (rst)
        ext_rd_stb |-> $past(!bus_cs_n && !bus_oe_n));

endmodule

bind hbr_host_regs hbr_host_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_cs_n   (bus_cs_n),
    .bus_oe_n   (bus_oe_n),
    .bus_we_n   (bus_we_n),
    .ext_addr   (ext_addr),
    .ext_wr_stb (ext_wr_stb),
    .ext_rd_stb (ext_rd_stb),
    .gpio_oe    (gpio_oe),
    .gpio_out   (gpio_out),
    .gpio_pu_en (gpio_pu_en),
    .gpio_pd_en (gpio_pd_en)
);

// File: tb/sim_hbr_host_regs.sv
module sim_hbr_host_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [5:0]  a_drv = '0;
    logic [7:0]  d_drv = '0;
    logic [15:0] pin_drv = '0;
    logic [7:0]  bus_dout, ext_wdata, ext_rdata;
    logic        bus_doe, ext_wr_stb, ext_rd_stb;
    logic [15:0] gpio_out, gpio_oe, gpio_pu_en, gpio_pd_en;
    logic [5:0]  ext_addr, ext_rd_addr;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    assign ext_rdata = {a_drv, 2'b01};

    hbr_host_regs u0 (
        .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
        .bus_addr(a_drv), .bus_din(d_drv), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .gpio_in(pin_drv), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .gpio_pu_en(gpio_pu_en), .gpio_pd_en(gpio_pd_en), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_wr_stb(ext_wr_stb), .ext_rdata(ext_rdata),
        .ext_rd_stb(ext_rd_stb), .ext_rd_addr(ext_rd_addr)
    );

    // behavioural reference state
    logic [7:0] m_dir[2], m_out[2], m_pu[2], m_pd[2], m_s1[2], m_s2[2];
    logic [7:0] m_scr[16];
    bit         m_seen, m_stb;
    logic [5:0] m_stb_addr;

    function automatic bit is_ext(input logic [5:0] a);
        return a >= 6'h06 && a <= 6'h2A;
    endfunction

    function automatic logic [7:0] m_read(input logic [5:0] a);
        if (a < 2)                    return m_dir[a[0]];
        if (a < 4)                    return m_out[a[0]];
        if (a < 6)                    return m_s2[a[0]];
        if (is_ext(a))                return {a, 2'b01};
        if (a == 6'h2B || a == 6'h2C) return m_pu[a == 6'h2C];
        if (a == 6'h2D || a == 6'h2E) return m_pd[a == 6'h2E];
        if (a >= 6'h30)               return m_scr[a[3:0]];
        return 8'h00;
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit rd, wr;
        rd = !cs_n && !oe_n;
        wr = !cs_n && !we_n && oe_n;
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_dir[i] = 0; m_out[i] = 0; m_pu[i] = 0; m_pd[i] = 0;
                m_s1[i] = 0; m_s2[i] = 0;
            end
            m_seen = 0; m_stb = 0; m_stb_addr = 0;
            return;
        end
        if (rd && !m_seen) m_stb_addr = a_drv;
        m_stb  = rd && !m_seen && is_ext(a_drv);
        m_seen = rd;
        for (int i = 0; i < 2; i++) begin
            m_s2[i] = m_s1[i];
            m_s1[i] = pin_drv[i*8 +: 8];
        end
        if (wr) begin
            case (a_drv)
                6'h00, 6'h01: m_dir[a_drv[0]] = d_drv;
                6'h02, 6'h03: m_out[a_drv[0]] = d_drv;
                6'h2B, 6'h2C: m_pu[a_drv == 6'h2C] = d_drv;
                6'h2D, 6'h2E: m_pd[a_drv == 6'h2E] = d_drv;
                default: if (a_drv >= 6'h30) m_scr[a_drv[3:0]] = d_drv;
            endcase
        end
    endtask

    // one bus cycle: drive, compare mid-cycle, advance model at the edge
    task automatic cyc(input string tag, input logic c, input logic o, input logic w,
                       input logic [5:0] a, input logic [7:0] d);
        logic [7:0] er;
        bit rd;
        cs_n = c; oe_n = o; we_n = w; a_drv = a; d_drv = d;
        #3;
        if (!rst) begin
            rd = !c && !o;
            check(tag, "gpio_oe",  gpio_oe,  {m_dir[1], m_dir[0]});
            check(tag, "gpio_out", gpio_out, {m_out[1], m_out[0]});
            check(tag, "pu_en", gpio_pu_en, {m_pu[1] & ~m_dir[1], m_pu[0] & ~m_dir[0]});
            check(tag, "pd_en", gpio_pd_en, {m_pd[1] & ~m_dir[1], m_pd[0] & ~m_dir[0]});
            check(tag, "bus_doe", {15'd0, bus_doe}, {15'd0, rd});
            er = rd ? m_read(a) : 8'h00;
            if (!$isunknown(er)) check(tag, "bus_dout", {8'd0, bus_dout}, {8'd0, er});
            check(tag, "ext_wr_stb", {15'd0, ext_wr_stb},
                  {15'd0, (!c && !w && o && is_ext(a))});
            if (!c && !w && o && is_ext(a)) begin
                check(tag, "ext_addr",  {10'd0, ext_addr}, {10'd0, a});
                check(tag, "ext_wdata", {8'd0, ext_wdata}, {8'd0, d});
            end
            check(tag, "ext_rd_stb", {15'd0, ext_rd_stb}, {15'd0, m_stb});
            if (m_stb) check(tag, "ext_rd_addr", {10'd0, ext_rd_addr}, {10'd0, m_stb_addr});
        end
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic wr(input string tag, input logic [5:0] a, input logic [7:0] d);
        cyc(tag, 0, 1, 0, a, d);
    endtask
    task automatic rd(input string tag, input logic [5:0] a);
        cyc(tag, 0, 0, 1, a, 8'h00);
    endtask
    task automatic idle(input string tag);
        cyc(tag, 1, 1, 1, 6'h00, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_scr[i] = 'x;
        rst = 1;
        repeat (3) idle("R1");
        rst = 0;
        // R1: reset values visible at the pads and in reads
        for (int i = 0; i < 6; i++) rd("R1", 6'(i));
        rd("R1", 6'h2B); rd("R1", 6'h2E);
        // R3 / R6: writes through the local map
        wr("R3", 6'h00, 8'hF0); wr("R3", 6'h02, 8'h5A);
        wr("R6", 6'h01, 8'h0F); wr("R6", 6'h03, 8'hC3);
        idle("R6");
        for (int i = 0; i < 4; i++) rd("R2", 6'(i));
        // R4: all three enables low reads, never writes
        cyc("R4", 0, 0, 0, 6'h00, 8'hFF);
        cyc("R4", 0, 0, 0, 6'h10, 8'hEE);
        rd("R4", 6'h00);
        // R5: pin view writes and deselected writes are ignored
        wr("R5", 6'h04, 8'hAA); wr("R5", 6'h05, 8'h55);
        cyc("R5", 1, 1, 0, 6'h00, 8'h00);
        cyc("R5", 1, 1, 0, 6'h31, 8'h77);
        rd("R5", 6'h04); rd("R5", 6'h00);
        // R7: pin synchroniser latency
        pin_drv = 16'hA53C;
        rd("R7", 6'h04); rd("R7", 6'h04); rd("R7", 6'h04);
        pin_drv = 16'h19E7;
        rd("R7", 6'h05); rd("R7", 6'h05); rd("R7", 6'h05);
        // R8: pull enables masked by direction
        wr("R8", 6'h2B, 8'hFF); wr("R8", 6'h2C, 8'hAA);
        wr("R8", 6'h2D, 8'h0F); wr("R8", 6'h2E, 8'hFF);
        wr("R8", 6'h00, 8'h3C); wr("R8", 6'h01, 8'h00);
        rd("R8", 6'h2B); rd("R8", 6'h2E);
        // R9: scratch storage
        for (int i = 0; i < 16; i++) wr("R9", 6'(6'h30 + i), 8'(i * 37 + 5));
        for (int i = 15; i >= 0; i--) rd("R9", 6'(6'h30 + i));
        // R10: unmapped hole
        wr("R10", 6'h2F, 8'hFF); rd("R10", 6'h2F);
        // R11: peripheral window
        wr("R11", 6'h06, 8'h12); wr("R11", 6'h2A, 8'h34); wr("R11", 6'h1B, 8'h56);
        rd("R11", 6'h0A); idle("R11"); rd("R11", 6'h2A); idle("R11");
        for (int i = 0; i < 6; i++) rd("R11", 6'(i));
        // R12: one read strobe per read cycle
        idle("R12");
        repeat (5) rd("R12", 6'h0A);
        idle("R12"); idle("R12");
        rd("R12", 6'h27); idle("R12"); idle("R12");
        repeat (3) rd("R12", 6'h02);
        idle("R12"); idle("R12");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule